// File: doc/BRIEF.md
# Vertical Sync Pulse Separator

This block receives a composite sync line with active-low pulses. The line carries a short pulse on every scanline and a much longer pulse once per frame. The block separates the two by duration alone. It drives a separate active-low frame pulse output, and that output never shows a scanline pulse. Downstream logic can use the frame pulse to pace per-frame work, for example to start drawing at the vertical retrace.

The input is brought into the clock domain by a two-stage synchronizer. A prescaler divides the system clock into a one-microsecond tick. A qualifier counts ticks while the synchronized input stays low, and any single high sample clears that count. When the low time reaches the qualification length, the output drops. From then on a timer keeps it low for a fixed 260 µs, whatever the input does in that time.

The prescaler phase is cleared while the block is idle and the input is high. This makes both the lag and the pulse length exact clock counts, with no jitter of one tick. A mode input picks between a 50 Hz and a 60 Hz set of timing parameters. By default the two sets are identical, so the output timing does not depend on the mode. The block has no data stream, so every pin is a plain level with no handshake.

Top module: `vsync_separator`

## Requirements
- R1: While reset is held, and after it is released, vsync_n is 1. This holds even if sync_n is held low during reset.
- R2: Scanline pulses never reach the output. These are low for 4 µs (200 cycles at the default 50 clocks per µs) and repeat every 64 µs (3200 cycles). vsync_n stays 1 throughout.
- R3: A low run shorter than 12 µs does not qualify. For example, 599 sampled-low cycles produce no output pulse. A single high sample clears the qualification count, so 500 low cycles, one high cycle and 500 more low cycles produce no pulse.
- R4: A low run of exactly 12 µs (600 sampled-low cycles) qualifies. The first clock edge at which sync_n is sampled low counts as edge 1. vsync_n is 1 after edge 601 and 0 after edge 602: two synchronizer stages plus 50 × 12 cycles.
- R5: vsync_n stays 0 for exactly 260 µs, which is 13000 clock cycles. With the edge numbering of R4 it returns to 1 after edge 13602.
- R6: Input activity during the output pulse has no effect. A 20-cycle high glitch inside the pulse leaves the fall at edge 602 and the rise at edge 13602.
- R7: After the pulse ends, a new pulse needs the input to be sampled high first. A single low run of 20000 cycles gives exactly one output pulse. A fresh 600-cycle low run after it gives another.
- R8: With mode_60 = 1 and the default parameters, the output timing matches R4 and R5: fall at edge 602, rise at edge 13602.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (default 50 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Composite sync, active low, asynchronous to clk |
| mode_60 | input | 1 | 1 selects the 60 Hz timing set, 0 the 50 Hz set |
| vsync_n | output | 1 | Separated frame pulse, active low |

## Verification
Every result is counted in clock edges from the first edge that samples sync_n low. The fall is due at edge 2 + 50·12 = 602 and the rise 13000 edges later, at 13602. Rejected runs must leave the output high for the whole observation window. The bench drives sync_n on falling clock edges and samples vsync_n on the falling edge after each rising edge, so it records the exact edge number of every transition. It then compares those numbers with the expected values, including one edge on each side of the 600-cycle qualification boundary.

// File: rtl/vsep_pkg.sv
package vsep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_REARM = 2'd2
  } vsep_state_e;
endpackage

// File: rtl/vsep_sync.sv
module vsep_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/vsep_tick.sv
module vsep_tick #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV == 1) begin : g_direct
      assign tick = run && !clr;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      assign tick = run && !clr && (cnt == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (run) cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
      end

      // R4: ticks are spaced by the prescaler, never back to back
      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/vsep_qual.sv
module vsep_qual #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = en && tick && (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!en || hit)         cnt <= '0;
    else if (tick)               cnt <= cnt + W'(1);
  end

  // R3: a new low run always starts counting from zero
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (cnt == '0));
endmodule

// File: rtl/vsep_pulse.sv
module vsep_pulse #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         busy,
  output logic         done,
  output logic         pulse_n
);
  logic [W-1:0] cnt;

  assign done = busy && tick && (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      pulse_n <= 1'b1;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      cnt     <= '0;
      pulse_n <= 1'b0;
    end else if (done) begin
      busy    <= 1'b0;
      cnt     <= '0;
      pulse_n <= 1'b1;
    end else if (busy && tick) begin
      cnt     <= cnt + W'(1);
    end
  end

  // R5: output stays low between ticks while the timer runs
  a_r5_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> !pulse_n);
  // R5: output releases only on the final tick of the timer
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_n) |-> $past(busy && tick));
endmodule

// File: rtl/vsync_separator.sv
module vsync_separator #(
  parameter int unsigned CLK_PER_US  = 50,
  parameter int unsigned QUAL_US_50  = 12,
  parameter int unsigned QUAL_US_60  = 12,
  parameter int unsigned PULSE_US_50 = 260,
  parameter int unsigned PULSE_US_60 = 260
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic mode_60,
  output logic vsync_n
);
  import vsep_pkg::*;

  localparam int unsigned QMAX = (QUAL_US_50 > QUAL_US_60) ? QUAL_US_50 : QUAL_US_60;
  localparam int unsigned PMAX = (PULSE_US_50 > PULSE_US_60) ? PULSE_US_50 : PULSE_US_60;
  localparam int unsigned QW   = $clog2(QMAX + 1);
  localparam int unsigned PW   = $clog2(PMAX + 1);

  vsep_state_e state, state_nx;
  logic        sync_s, low, mode_r;
  logic        tick, tick_run, tick_clr;
  logic        qual_en, qual_hit;
  logic        p_busy, p_done, p_out_n;
  logic [QW-1:0] qual_lim;
  logic [PW-1:0] pulse_lim;

  vsep_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sync_n), .dout(sync_s)
  );

  assign low = !sync_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        mode_r <= 1'b0;
    else if (state == ST_IDLE && !low) mode_r <= mode_60;
  end

  assign qual_lim  = mode_r ? QW'(QUAL_US_60)  : QW'(QUAL_US_50);
  assign pulse_lim = mode_r ? PW'(PULSE_US_60) : PW'(PULSE_US_50);

  assign tick_run = (state == ST_HOLD) || (state == ST_IDLE && low);
  assign tick_clr = (state == ST_REARM) || (state == ST_IDLE && !low);

  vsep_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(tick_run), .clr(tick_clr), .tick(tick)
  );

  assign qual_en = (state == ST_IDLE) && low;

  vsep_qual #(.W(QW)) u_qual (
    .clk(clk), .rst_n(rst_n), .en(qual_en), .tick(tick),
    .limit(qual_lim), .hit(qual_hit)
  );

  vsep_pulse #(.W(PW)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(qual_hit), .tick(tick),
    .limit(pulse_lim), .busy(p_busy), .done(p_done), .pulse_n(p_out_n)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (qual_hit) state_nx = ST_HOLD;
      ST_HOLD:  if (p_done)   state_nx = low ? ST_REARM : ST_IDLE;
      ST_REARM: if (!low)     state_nx = ST_IDLE;
      default:                state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign vsync_n = p_out_n;

  // R2: the output may only fall after the synchronized input was low
  a_r2_fall_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> $past(low));
  // R6: the pulse is held low for the whole hold state
  a_r6_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !vsync_n);
  // R7: no pulse while waiting for the input to go high again
  a_r7_rearm_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REARM) |-> vsync_n);
  // R6: timer and state machine agree on activity
  a_r6_busy_match: assert property (@(posedge clk) disable iff (!rst_n)
    p_busy == (state == ST_HOLD));
endmodule

// File: tb/vsync_separator_bench.sv
module vsync_separator_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic mode_60 = 1'b0;
  logic vsync_n;

  int checks = 0;
  int fails  = 0;

  localparam int FALL_AT = 602;
  localparam int RISE_AT = 13602;

  always #10 clk = ~clk;

  vsync_separator u_vsync_separator (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .mode_60(mode_60), .vsync_n(vsync_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    sync_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // Drive sync_n low for low_len sampled edges, optionally with a 20-cycle
  // high glitch starting at bounce_at; record output transitions by edge number.
  task automatic drive_low(input int low_len, input int bounce_at, input int total,
                           output int fall_n, output int rise_n, output int falls);
    logic prev;
    fall_n = -1; rise_n = -1; falls = 0;
    @(negedge clk);
    sync_n = 1'b0;
    prev = vsync_n;
    for (int n = 1; n <= total; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (prev && !vsync_n) begin
        falls++;
        if (fall_n < 0) fall_n = n;
      end
      if (!prev && vsync_n && rise_n < 0) rise_n = n;
      prev = vsync_n;
      if (n == low_len) sync_n = 1'b1;
      if (bounce_at > 0 && n == bounce_at) sync_n = 1'b1;
      if (bounce_at > 0 && n == bounce_at + 20) sync_n = 1'b0;
    end
    sync_n = 1'b1;
  endtask

  task automatic t_reset;
    int lows = 0;
    sync_n = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!vsync_n) lows++;
    end
    check(lows == 0, "R1 output high during reset", lows, 0);
    sync_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(vsync_n == 1'b1, "R1 output high after reset", vsync_n, 1);
  endtask

  task automatic t_lines;
    int f, r, c, total_falls;
    total_falls = 0;
    for (int l = 0; l < 8; l++) begin
      drive_low(200, 0, 3200, f, r, c);
      total_falls += c;
    end
    check(total_falls == 0, "R2 scanline pulses rejected", total_falls, 0);
  endtask

  task automatic t_short;
    int f, r, c;
    drive_low(599, 0, 1000, f, r, c);
    check(c == 0, "R3 599-cycle low rejected", c, 0);
    idle(10);
    drive_low(500, 0, 500, f, r, c);
    drive_low(500, 0, 2000, f, r, c);
    check(c == 0, "R3 one high sample restarts count", c, 0);
    idle(10);
  endtask

  task automatic t_exact;
    int f, r, c;
    drive_low(600, 0, 14000, f, r, c);
    check(f == FALL_AT, "R4 fall edge at 12 us boundary", f, FALL_AT);
    check(r == RISE_AT, "R5 rise edge after 260 us", r, RISE_AT);
    check((r - f) == 13000, "R5 low time in cycles", r - f, 13000);
    check(c == 1, "R4 single pulse", c, 1);
    idle(10);
  endtask

  task automatic t_glitch;
    int f, r, c;
    drive_low(5000, 1000, 14000, f, r, c);
    check(f == FALL_AT, "R6 fall edge with glitch", f, FALL_AT);
    check(r == RISE_AT, "R6 glitch ignored during pulse", r, RISE_AT);
    check(c == 1, "R6 one pulse despite glitch", c, 1);
    idle(10);
  endtask

  task automatic t_rearm;
    int f, r, c;
    drive_low(20000, 0, 21000, f, r, c);
    check(c == 1, "R7 long low gives one pulse", c, 1);
    check(r == RISE_AT, "R7 rise edge on long low", r, RISE_AT);
    idle(10);
    drive_low(600, 0, 14000, f, r, c);
    check(f == FALL_AT, "R7 rearmed after high sample", f, FALL_AT);
    idle(10);
  endtask

  task automatic t_mode60;
    int f, r, c;
    mode_60 = 1'b1;
    idle(10);
    drive_low(600, 0, 14000, f, r, c);
    check(f == FALL_AT, "R8 60 Hz mode fall edge", f, FALL_AT);
    check(r == RISE_AT, "R8 60 Hz mode rise edge", r, RISE_AT);
    mode_60 = 1'b0;
    idle(10);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_lines();
    t_short();
    t_exact();
    t_glitch();
    t_rearm();
    t_mode60();
    finish_run();
  end
endmodule